// File: doc/BRIEF.md
# MMU Control Register File

This block is a bank of CPU control registers that sit beside the memory-management unit. It holds ten registers on a simple register bus:

- MMU control.
- Page-table-entry high.
- Page-table-entry low.
- Page-table-entry assist.
- Translation base.
- Faulting address.
- Trap code.
- Exception event.
- Interrupt event.
- A 16-bit refresh counter.

Each register keeps only the bits that its write mask allows. Some writes have side effects. Setting the invalidate bit of the MMU control register sends a one-cycle TLB invalidate pulse. The bit itself is never stored. Changing the address-space identifier in the page-table-entry high register sends a one-cycle TLB flush pulse. Each read of the refresh counter returns its value and then advances it by one.

The bus takes at most one request per clock. The request is sampled on a rising edge. The read data, the error flag and any side-effect pulse appear in the cycle after that edge, for exactly one cycle. The TLB, the table walker and the refresh engine are outside this block. They only receive the pulses.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset every register and the refresh counter hold 0, and rsp_rdata, rsp_err, tlb_inval_o and tlb_flush_o are 0. No pulse is produced while reset is held or in the first cycle after it.
- R2: A write to word offset 0 (MMU control) stores every bit except the invalidate bit (bit INVAL_BIT, default 2), which always reads 0. If that bit is 1 in the written data, tlb_inval_o is 1 for the single cycle after the write.
- R3: A write to offset 1 (entry high) stores all 32 bits. tlb_flush_o is 1 for the single cycle after the write exactly when the written bits 7:0 differ from the stored bits 7:0.
- R4: Offset 3 (entry assist) keeps only bits 3:0 of a write. Its other bits read as 0.
- R5: Offsets 6 (trap code), 7 (exception event) and 8 (interrupt event) keep only bits 10:0 of a write.
- R6: Offsets 2 (entry low), 4 (translation base) and 5 (faulting address) store all 32 bits unchanged.
- R7: A read of offset 9 (refresh counter) returns the current count, zero-extended, and the count then becomes count+1, wrapping from 0xFFFF to 0.
- R8: A write to offset 9 loads bits 15:0 of the written data into the counter.
- R9: Any access to an offset of 10 or above returns rsp_rdata 0 and sets rsp_err for one cycle. It changes no register and makes no pulse.
- R10: Read data appears on rsp_rdata in the cycle after the request edge. In every other cycle rsp_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Word offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| rsp_err | output | 1 | Unmapped-offset flag, one cycle after the request |
| tlb_inval_o | output | 1 | One-cycle TLB invalidate pulse |
| tlb_flush_o | output | 1 | One-cycle TLB flush pulse on an identifier change |

## Verification
Some rules hold on every cycle, and the assertions check these:

- A pulse appears only after the matching write, and the flush pulse only when the identifier really changed.
- The invalidate bit and the masked upper bits of the assist register always read 0.
- An error response always carries zero data.
- Each refresh read advances the count by exactly one.

Other behaviour depends on values and their history, and only the bench scenarios can show it. These include:

- The exact value each mask keeps.
- The count sequence and its wrap at 0xFFFF.
- A rewrite of the same identifier with new upper bits making no flush.
- Back-to-back pulses.
- An unmapped write leaving every register untouched.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int DATA_W    = 32;
  localparam int IDX_CTL   = 0;
  localparam int IDX_PTEH  = 1;
  localparam int IDX_PTEL  = 2;
  localparam int IDX_ASST  = 3;
  localparam int IDX_BASE  = 4;
  localparam int IDX_FADDR = 5;
  localparam int IDX_TRAP  = 6;
  localparam int IDX_EXEV  = 7;
  localparam int IDX_INEV  = 8;
  localparam int IDX_REF   = 9;
  localparam int NUM_BANK  = 9;
  localparam int NUM_SLOTS = 10;

  function automatic logic [DATA_W-1:0] low_ones(input int w);
    if (w >= DATA_W) return '1;
    return (DATA_W'(1) << w) - DATA_W'(1);
  endfunction

  // Bits of a written word that a bank slot keeps.
  function automatic logic [DATA_W-1:0] keep_mask(input int idx, input int inval_bit,
                                                  input int assist_w, input int code_w);
    case (idx)
      IDX_CTL:                     return ~(DATA_W'(1) << inval_bit);
      IDX_ASST:                    return low_ones(assist_w);
      IDX_TRAP, IDX_EXEV, IDX_INEV: return low_ones(code_w);
      default:                     return '1;
    endcase
  endfunction
endpackage

// File: rtl/mmu_addr_decode.sv
module mmu_addr_decode #(
  parameter int ADDR_W = 4,
  parameter int NSLOT  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSLOT-1:0]  sel,
  output logic              hit
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign sel[i] = (addr == ADDR_W'(i));
  end
  assign hit = |sel;
endmodule

// File: rtl/mmu_refresh_ctr.sv
module mmu_refresh_ctr #(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REF_W-1:0] wdata,
  output logic [REF_W-1:0] count
);
  function automatic logic [REF_W-1:0] bump(input logic [REF_W-1:0] v);
    return v + REF_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (wr_en) count <= wdata;
    else if (rd_en) count <= bump(count);
  end

  // R7
  ref_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && !wr_en) |-> (count == REF_W'($past(count) + REF_W'(1))));
endmodule

// File: rtl/mmu_event_gen.sv
module mmu_event_gen #(
  parameter int ASID_W    = 8,
  parameter int INVAL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              hi_wr,
  input  logic [31:0]       wdata,
  input  logic [ASID_W-1:0] asid_q,
  output logic              inval_o,
  output logic              flush_o
);
  function automatic logic asid_moved(input logic [ASID_W-1:0] old_id,
                                      input logic [ASID_W-1:0] new_id);
    return old_id != new_id;
  endfunction

  logic inval_evt, flush_evt;
  assign inval_evt = ctl_wr && wdata[INVAL_BIT];
  assign flush_evt = hi_wr && asid_moved(asid_q, wdata[ASID_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inval_o <= 1'b0;
      flush_o <= 1'b0;
    end else begin
      inval_o <= inval_evt;
      flush_o <= flush_evt;
    end
  end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!inval_o && !flush_o));
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs #(
  parameter int ADDR_W    = 4,
  parameter int ASID_W    = 8,
  parameter int REF_W     = 16,
  parameter int CODE_W    = 11,
  parameter int ASSIST_W  = 4,
  parameter int INVAL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              tlb_inval_o,
  output logic              tlb_flush_o
);
  import mmu_regs_pkg::*;

  localparam int NSLOT = NUM_SLOTS;
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(IDX_CTL);
  localparam logic [ADDR_W-1:0] A_PTEH = ADDR_W'(IDX_PTEH);
  localparam logic [ADDR_W-1:0] A_ASST = ADDR_W'(IDX_ASST);

  logic [NSLOT-1:0] slot_sel, wr_sel, rd_sel;
  logic             slot_hit;
  logic [31:0]      bank_q [NUM_BANK];
  logic [REF_W-1:0] ref_count;
  logic [31:0]      rd_word;

  mmu_addr_decode #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_dec (
    .addr(req_addr), .sel(slot_sel), .hit(slot_hit)
  );

  assign wr_sel = slot_sel & {NSLOT{req_valid &&  req_write}};
  assign rd_sel = slot_sel & {NSLOT{req_valid && !req_write}};

  for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
    localparam logic [31:0] KEEP = keep_mask(g, INVAL_BIT, ASSIST_W, CODE_W);
    always_ff @(posedge clk) begin
      if (!rst_n)         bank_q[g] <= '0;
      else if (wr_sel[g]) bank_q[g] <= req_wdata & KEEP;
    end
  end

  mmu_refresh_ctr #(.REF_W(REF_W)) u_ref (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_sel[IDX_REF]), .wr_en(wr_sel[IDX_REF]),
    .wdata(req_wdata[REF_W-1:0]), .count(ref_count)
  );

  mmu_event_gen #(.ASID_W(ASID_W), .INVAL_BIT(INVAL_BIT)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(wr_sel[IDX_CTL]), .hi_wr(wr_sel[IDX_PTEH]),
    .wdata(req_wdata), .asid_q(bank_q[IDX_PTEH][ASID_W-1:0]),
    .inval_o(tlb_inval_o), .flush_o(tlb_flush_o)
  );

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_BANK; i++) begin
      rd_word = rd_word | (bank_q[i] & {32{rd_sel[i]}});
    end
    rd_word = rd_word | ({{(32-REF_W){1'b0}}, ref_count} & {32{rd_sel[IDX_REF]}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= rd_word;
      rsp_err   <= req_valid && !slot_hit;
    end
  end

  // R2
  inval_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_inval_o |-> $past(req_valid && req_write && req_addr == A_CTL && req_wdata[INVAL_BIT]));
  // R2
  ctl_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_write && req_addr == A_CTL) |-> !rsp_rdata[INVAL_BIT]);
  // R3
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_o |-> ($past(req_valid && req_write && req_addr == A_PTEH)
                     && ($past(req_wdata[ASID_W-1:0]) != $past(bank_q[IDX_PTEH][ASID_W-1:0]))));
  // R4
  assist_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_write && req_addr == A_ASST) |-> (rsp_rdata[31:ASSIST_W] == '0));
  // R9
  err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0 && !tlb_inval_o && !tlb_flush_o));
endmodule

// File: tb/sim_mmu_ctl_regs.sv
module sim_mmu_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_err, tlb_inval_o, tlb_flush_o;

  int checks = 0, errors = 0;
  logic [31:0] m_bank [9];
  int          m_ref;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .tlb_inval_o(tlb_inval_o), .tlb_flush_o(tlb_flush_o)
  );

  function automatic logic [31:0] model_keep(input int a);
    if (a == 0) return 32'hFFFF_FFFB;
    if (a == 3) return 32'h0000_000F;
    if (a >= 6 && a <= 8) return 32'h0000_07FF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One bus cycle; the model predicts every output for the following cycle.
  task automatic step(input logic v, input logic w, input int a, input logic [31:0] d, input string tag);
    logic [31:0] e_rd; logic e_err, e_inv, e_fl;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = 4'(a); req_wdata = d;
    e_rd = 0; e_err = 0; e_inv = 0; e_fl = 0;
    if (v) begin
      if (a >= 10) e_err = 1;
      else if (a == 9) begin
        if (w) m_ref = int'(d[15:0]);
        else begin e_rd = 32'(m_ref); m_ref = (m_ref + 1) % 65536; end
      end else if (w) begin
        e_inv = (a == 0) && d[2];
        e_fl  = (a == 1) && (d[7:0] != m_bank[1][7:0]);
        m_bank[a] = d & model_keep(a);
      end else e_rd = m_bank[a];
    end
    @(posedge clk); #1;
    check(tag, "rdata", rsp_rdata, e_rd);
    check(tag, "err", 32'(rsp_err), 32'(e_err));
    check(tag, "inval", 32'(tlb_inval_o), 32'(e_inv));
    check(tag, "flush", 32'(tlb_flush_o), 32'(e_fl));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) m_bank[i] = 0;
    m_ref = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "rdata in reset", rsp_rdata, 0);
    check("R1", "pulses in reset", 32'({tlb_inval_o, tlb_flush_o, rsp_err}), 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, "R1");
    for (int i = 0; i < 10; i++) step(1, 0, i, 0, "R1");
    // R10 idle cycles keep data at 0
    step(0, 0, 0, 32'hFFFF_FFFF, "R10");
    // R2
    step(1, 1, 0, 32'hFFFF_FFFF, "R2");
    step(1, 0, 0, 0, "R2");
    step(1, 1, 0, 32'h0000_0101, "R2");
    step(1, 1, 0, 32'h0000_0004, "R2");
    step(1, 1, 0, 32'h0000_0004, "R2");
    step(1, 0, 0, 0, "R2");
    // R3
    step(1, 1, 1, 32'h1234_5600, "R3");
    step(1, 1, 1, 32'h0000_00AB, "R3");
    step(1, 1, 1, 32'hFFFF_00AB, "R3");
    step(1, 0, 1, 0, "R3");
    step(1, 1, 1, 32'hFFFF_0001, "R3");
    // R4
    step(1, 1, 3, 32'hFFFF_FFFF, "R4");
    step(1, 0, 3, 0, "R4");
    // R5
    step(1, 1, 6, 32'hFFFF_FFFF, "R5");
    step(1, 1, 7, 32'hA5A5_F123, "R5");
    step(1, 1, 8, 32'h0000_0800, "R5");
    for (int i = 6; i <= 8; i++) step(1, 0, i, 0, "R5");
    // R6
    step(1, 1, 2, 32'hDEAD_BEEF, "R6");
    step(1, 1, 4, 32'h8000_0001, "R6");
    step(1, 1, 5, 32'hCAFE_F00D, "R6");
    for (int i = 2; i <= 5; i++) step(1, 0, i, 0, "R6");
    // R7
    for (int i = 0; i < 4; i++) step(1, 0, 9, 0, "R7");
    // R8
    step(1, 1, 9, 32'hABCD_1234, "R8");
    step(1, 0, 9, 0, "R8");
    step(1, 1, 9, 32'h0000_FFFF, "R7");
    step(1, 0, 9, 0, "R7");
    step(1, 0, 9, 0, "R7");
    // R9
    step(1, 0, 10, 0, "R9");
    step(1, 0, 15, 0, "R9");
    step(1, 1, 12, 32'hFFFF_FFFF, "R9");
    step(1, 1, 10, 32'h0000_0004, "R9");
    for (int i = 0; i < 10; i++) step(1, 0, i, 0, "R9");
    step(0, 0, 0, 0, "R10");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule